// File: doc/BRIEF.md
# Burst Address Generator

This block produces the internal address for one port of a synchronous memory. At each rising clock edge it picks one of four sources for the address of the current access. It can clear to zero, take an address from outside, step to the next location, or keep the location it used last. The controls for these choices are active-low. They are decoded in a fixed priority order.

The selected address is driven combinationally. It is formed from the stored address of the previous cycle and the controls of the present cycle, so the memory array can use it in the same cycle. The address chosen at each edge is captured and becomes the base for the next cycle. Chip enable has no part in this path. The counter loads, steps and clears whether the port is selected or not.

A synchronous block reset clears the stored address. This reset is separate from the active-low clear control.

Top module: `addr_burst_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the stored address becomes 0. With all three controls high after reset, `cur_addr` reads 0.
- R2: When `clr_n` is low, `cur_addr` is 0 whatever `strobe_n`, `step_n` and `ext_addr` are. That zero is also the base for the next cycle, so clearing needs no extra cycle.
- R3: When `clr_n` is high and `strobe_n` is low, `cur_addr` equals `ext_addr`, and that value is stored for the next cycle.
- R4: When `clr_n` and `strobe_n` are high and `step_n` is low, `cur_addr` is the previous cycle's address plus one, in that same cycle.
- R5: When all three controls are high, `cur_addr` equals the previous cycle's address, over any number of cycles.
- R6: A step from the all-ones address (0xFFFF at the default width) gives 0.
- R7: `strobe_n` low takes priority over `step_n` low. No increment is applied in a cycle that loads an external address.
- R8: A run of consecutive steps after a load yields consecutive addresses, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous block reset, active high |
| ext_addr | input | AW | External address, taken when the strobe is low |
| strobe_n | input | 1 | Load external address, active low |
| step_n | input | 1 | Advance the address by one, active low |
| clr_n | input | 1 | Clear the address to zero, active low, highest priority |
| cur_addr | output | AW | Address used by the current access |

## Verification
The bench builds the block with the default width of 16 bits. At that width a single load of 0xFFFF followed by one step reaches the wrap boundary, and a long counting run is not needed to get there. Directed sequences combine conflicting controls in the same cycle to expose the priority order. The checks confirm that each result becomes the base for the following cycle.

// File: rtl/addr_burst_gen.sv
module addr_burst_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ext_addr,
  input  logic          strobe_n,
  input  logic          step_n,
  input  logic          clr_n,
  output logic [AW-1:0] cur_addr
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] base_q;
  logic          hist_ok;

  assign cur_addr = !clr_n    ? '0
                  : !strobe_n ? ext_addr
                  : !step_n   ? base_q + ONE
                  :             base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      hist_ok <= 1'b0;
    end else begin
      base_q  <= cur_addr;
      hist_ok <= 1'b1;
    end
  end

  p_clear_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(!clr_n) && clr_n && strobe_n && step_n) |-> (cur_addr == '0));

  p_load_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(clr_n && !strobe_n) && clr_n && strobe_n && step_n)
      |-> (cur_addr == $past(ext_addr)));

  p_step_next_r4: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && clr_n && strobe_n && !step_n)
      |-> (cur_addr == AW'($past(cur_addr) + ONE)));

  p_hold_same_r5: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && clr_n && strobe_n && step_n) |-> (cur_addr == $past(cur_addr)));

  p_strobe_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !strobe_n && !step_n) |-> (cur_addr == ext_addr));

endmodule

// File: tb/addr_burst_gen_tb_top.sv
module addr_burst_gen_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] ext_addr;
  logic          strobe_n, step_n, clr_n;
  logic [AW-1:0] cur_addr;

  int vectors = 0;
  int errs = 0;
  logic [AW-1:0] mprev;
  bit done = 0;

  addr_burst_gen #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
    .step_n(step_n), .clr_n(clr_n), .cur_addr(cur_addr)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [AW-1:0] exp);
    vectors++;
    if (cur_addr !== exp) begin
      errs++;
      $display("FAIL %s: cur_addr=%h expected=%h", req, cur_addr, exp);
    end
  endtask

  task automatic apply(input string req, input logic c, input logic s,
                       input logic e, input logic [AW-1:0] a);
    logic [AW-1:0] exp;
    @(negedge clk);
    clr_n = c; strobe_n = s; step_n = e; ext_addr = a;
    #1;
    if (!c)      exp = '0;
    else if (!s) exp = a;
    else if (!e) exp = mprev + 1'b1;
    else         exp = mprev;
    chk(req, exp);
    mprev = exp;
  endtask

  task automatic t_reset();
    rst = 1'b1; clr_n = 1'b1; strobe_n = 1'b0; step_n = 1'b1; ext_addr = 16'h1234;
    repeat (3) @(negedge clk);
    strobe_n = 1'b1;
    rst = 1'b0;
    mprev = '0;
    apply("R1", 1'b1, 1'b1, 1'b1, 16'hBEEF);
  endtask

  task automatic t_load_hold();
    apply("R3", 1'b1, 1'b0, 1'b1, 16'h0A55);
    for (int i = 0; i < 4; i++) apply("R5", 1'b1, 1'b1, 1'b1, 16'h7777);
  endtask

  task automatic t_burst();
    apply("R3", 1'b1, 1'b0, 1'b1, 16'h0100);
    for (int i = 0; i < 6; i++) apply("R8", 1'b1, 1'b1, 1'b0, 16'h3333);
    apply("R4", 1'b1, 1'b1, 1'b0, 16'h0000);
    apply("R5", 1'b1, 1'b1, 1'b1, 16'h0000);
  endtask

  task automatic t_clear();
    apply("R3", 1'b1, 1'b0, 1'b1, 16'h4242);
    apply("R2", 1'b0, 1'b0, 1'b0, 16'h9999);
    apply("R2", 1'b1, 1'b1, 1'b1, 16'h9999);
    apply("R2", 1'b0, 1'b1, 1'b0, 16'h1111);
    apply("R4", 1'b1, 1'b1, 1'b0, 16'h1111);
  endtask

  task automatic t_wrap();
    apply("R3", 1'b1, 1'b0, 1'b1, 16'hFFFE);
    apply("R4", 1'b1, 1'b1, 1'b0, 16'h0000);
    apply("R6", 1'b1, 1'b1, 1'b0, 16'h0000);
    apply("R6", 1'b1, 1'b1, 1'b1, 16'h0000);
  endtask

  task automatic t_priority();
    apply("R3", 1'b1, 1'b0, 1'b1, 16'h2000);
    apply("R7", 1'b1, 1'b0, 1'b0, 16'h5000);
    apply("R7", 1'b1, 1'b0, 1'b0, 16'h5000);
    apply("R4", 1'b1, 1'b1, 1'b0, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_load_hold();
    t_burst();
    t_clear();
    t_wrap();
    t_priority();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule